// File: doc/BRIEF.md
# Linked-List First-Fit Search Engine

This block walks a singly linked list stored in a word-addressed memory and returns the first node whose value is at least a given key. A free-memory allocator uses it to find the first segment large enough for a request. The caller supplies a start address, a key and a visit budget, then pulses `start`. The engine reads one link word at a time, compares it, and follows the chain.

A search ends in one of three ways: a node matched, the chain ran out, or the budget of visited nodes was used up. Completion is a one-cycle `done` pulse. `status` and `result_addr` are updated in that cycle and hold their values until the next search completes.

The memory port is a plain synchronous read with a fixed latency of one cycle. It has no valid/ready pair and applies no back-pressure: the word for an address presented with `rd_en` must be on `rd_data` in the following cycle. Only one read is in flight at a time. The start handshake is also plain: a pulse while `busy` is low starts a search, and a pulse while `busy` is high is dropped.

Top module: `llsrch_engine`

## Requirements
- R1: While reset is held and immediately after it is released, `done`, `busy` and `rd_en` are 0, and `status` and `result_addr` are 0.
- R2: A 48-bit link word carries the next-node address in bits [19:0] and the node value in bits [39:20]. Bits [47:40] have no effect on the search.
- R3: A start with a nonzero address and a nonzero budget reads that address in the cycle after the start pulse. Each node takes two cycles, so a match on the first node gives `done` three cycles after the start cycle, and `rd_en` is never high in two consecutive cycles.
- R4: The search stops at the first node whose value is greater than or equal to the key (unsigned). It pulses `done` with `status` = 2'b01 and `result_addr` = the address of that node.
- R5: A node value exactly equal to the key counts as a match.
- R6: If a node with next address 0 does not match, the search ends with `status` = 2'b10 and `result_addr` = 0.
- R7: `limit` is the largest number of nodes examined. If that many nodes are examined without a match and without reaching the tail, the search ends with `status` = 2'b11, `result_addr` = 0, and no further read is issued.
- R8: A start address of 0 is an empty list. The search ends with `status` = 2'b10 in the cycle after the start, with no read.
- R9: A `limit` of 0 with a nonzero start address ends with `status` = 2'b11 in the cycle after the start, with no read.
- R10: A `start` pulse while `busy` is high is ignored and does not change the running search.
- R11: `done` is high for exactly one cycle per search. `status` and `result_addr` change only in a cycle where `done` is high.
- R12: When one node triggers more than one outcome, a match wins over the tail, and the tail wins over the budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (accepted only when idle) |
| start_addr | input | 20 | Address of the first node, 0 for an empty list |
| key | input | 20 | Minimum node value being sought |
| limit | input | 16 | Maximum number of nodes to examine |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 01 found, 10 end of list, 11 budget exhausted, 00 after reset |
| result_addr | output | 20 | Address of the matching node, 0 otherwise |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 20 | Memory word address |
| rd_data | input | 48 | Memory word, valid the cycle after `rd_en` |

## Verification
One test chain of four nodes with increasing values is searched with several keys. A key below a node value, equal to a node value, and above every node value separate the `>=` comparison from a strict `>` test and from end-of-list detection. Budgets smaller than, equal to and larger than the distance to the match or tail check both the timeout count and the priority between the three outcomes. The zero start address and zero budget cases check that the early exits issue no reads. A second start pulse in the middle of a walk shows whether the running search is protected. Unused high bits are set in every link word, so a field extraction that includes them changes the result.

// File: rtl/llsrch_pkg.sv
package llsrch_pkg;
  typedef enum logic [1:0] {
    SRCH_NONE  = 2'b00,
    SRCH_FOUND = 2'b01,
    SRCH_END   = 2'b10,
    SRCH_TMO   = 2'b11
  } srch_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_WAIT
  } srch_phase_e;
endpackage

// File: rtl/llsrch_field.sv
module llsrch_field #(
  parameter int WORD_W = 48,
  parameter int ADDR_W = 20,
  parameter int VAL_W  = 20
) (
  input  logic [WORD_W-1:0] word,
  input  logic [VAL_W-1:0]  key,
  output logic [ADDR_W-1:0] next_addr,
  output logic              hit,
  output logic              tail
);
  localparam int VAL_LO = ADDR_W;
  localparam int VAL_HI = ADDR_W + VAL_W - 1;

  logic [VAL_W-1:0] node_val;

  always_comb begin
    next_addr = word[ADDR_W-1:0];
    node_val  = word[VAL_HI:VAL_LO];
    hit       = (node_val >= key);
    tail      = (next_addr == '0);
  end
endmodule

// File: rtl/llsrch_budget.sv
module llsrch_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] limit,
  input  logic             step,
  output logic             zero_limit,
  output logic             last
);
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      seen    <= '0;
    end else if (load) begin
      limit_q <= limit;
      seen    <= '0;
    end else if (step) begin
      seen <= seen + 1'b1;
    end
  end

  always_comb begin
    zero_limit = (limit == '0);
    last       = (CNT_W'(seen + 1'b1) == limit_q);
  end

  // R7
  budget_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (seen < limit_q));
endmodule

// File: rtl/llsrch_fsm.sv
module llsrch_fsm
  import llsrch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int VAL_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [VAL_W-1:0]  key,
  input  logic              hit,
  input  logic              tail,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              last,
  input  logic              zero_limit,
  output logic [VAL_W-1:0]  key_q,
  output logic              load,
  output logic              step,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] result_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  srch_phase_e      ph;
  logic [ADDR_W-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      cur         <= '0;
      key_q       <= '0;
      done        <= 1'b0;
      status      <= SRCH_NONE;
      result_addr <= '0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          key_q <= key;
          cur   <= start_addr;
          if (start_addr == '0) begin
            done        <= 1'b1;
            status      <= SRCH_END;
            result_addr <= '0;
          end else if (zero_limit) begin
            done        <= 1'b1;
            status      <= SRCH_TMO;
            result_addr <= '0;
          end else begin
            ph <= PH_ISSUE;
          end
        end
        PH_ISSUE: ph <= PH_WAIT;
        PH_WAIT: begin
          if (hit) begin
            done        <= 1'b1;
            status      <= SRCH_FOUND;
            result_addr <= cur;
            ph          <= PH_IDLE;
          end else if (tail) begin
            done        <= 1'b1;
            status      <= SRCH_END;
            result_addr <= '0;
            ph          <= PH_IDLE;
          end else if (last) begin
            done        <= 1'b1;
            status      <= SRCH_TMO;
            result_addr <= '0;
            ph          <= PH_IDLE;
          end else begin
            cur <= next_addr;
            ph  <= PH_ISSUE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (ph != PH_IDLE);
    rd_en   = (ph == PH_ISSUE);
    rd_addr = cur;
    load    = (ph == PH_IDLE) && start;
    step    = (ph == PH_WAIT);
  end

  // R3
  no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != $past(status)) |-> done);

  // R6
  result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != SRCH_FOUND) |-> (result_addr == '0));

  // R4
  found_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == SRCH_FOUND) |-> (result_addr != '0));
endmodule

// File: rtl/llsrch_engine.sv
module llsrch_engine #(
  parameter int WORD_W = 48,
  parameter int ADDR_W = 20,
  parameter int VAL_W  = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [VAL_W-1:0]  key,
  input  logic [CNT_W-1:0]  limit,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] result_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data
);
  logic [VAL_W-1:0]  key_q;
  logic [ADDR_W-1:0] next_addr;
  logic hit, tail, last, zero_limit, load, step;

  llsrch_field #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .VAL_W(VAL_W)) u_field (
    .word(rd_data), .key(key_q), .next_addr(next_addr), .hit(hit), .tail(tail)
  );

  llsrch_budget #(.CNT_W(CNT_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(load), .limit(limit), .step(step),
    .zero_limit(zero_limit), .last(last)
  );

  llsrch_fsm #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .key(key),
    .hit(hit), .tail(tail), .next_addr(next_addr), .last(last),
    .zero_limit(zero_limit), .key_q(key_q), .load(load), .step(step),
    .busy(busy), .done(done), .status(status), .result_addr(result_addr),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );
endmodule

// File: tb/test_llsrch_engine.sv
module test_llsrch_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] start_addr = '0;
  logic [19:0] key = '0;
  logic [15:0] limit = '0;
  logic        busy, done, rd_en;
  logic [1:0]  status;
  logic [19:0] result_addr, rd_addr;
  logic [47:0] rd_data;
  logic [47:0] mem [64];

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[5:0]];

  llsrch_engine i_llsrch_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .key(key),
    .limit(limit), .busy(busy), .done(done), .status(status),
    .result_addr(result_addr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [19:0] nxt, input logic [19:0] val);
    mem[idx] = {8'hC3, val, nxt};
  endtask

  task automatic run(input logic [19:0] a, input logic [19:0] k, input logic [15:0] lim,
                     input bit poke, output logic [1:0] st, output logic [19:0] ra,
                     output int cyc, output int nrd);
    @(negedge clk);
    start = 1'b1; start_addr = a; key = k; limit = lim;
    cyc = 0; nrd = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    forever begin
      if (rd_en) nrd++;
      if (done) break;
      if (poke && cyc == 2) begin
        start = 1'b1; start_addr = 20'd0; key = 20'd0; limit = 16'd0;
      end else start = 1'b0;
      cyc++;
      if (cyc > 500) begin
        chk(1'b0, "R11 no done", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    st = status; ra = result_addr;
    @(negedge clk);
    chk(!done, "R11 done width", done, 0);
    chk(status == st && result_addr == ra, "R11 hold", status, st);
  endtask

  task automatic t_reset();
    chk(!done && !busy && !rd_en, "R1 ctl", {done, busy, rd_en}, 0);
    chk(status == 2'b00, "R1 status", status, 0);
    chk(result_addr == 20'd0, "R1 result", result_addr, 0);
  endtask

  task automatic t_found();
    logic [1:0] st; logic [19:0] ra; int c, n;
    run(20'd1, 20'd8, 16'd100, 1'b0, st, ra, c, n);
    chk(st == 2'b01, "R4 status", st, 1);
    chk(ra == 20'd9, "R4 addr R2", ra, 9);
    chk(n == 3, "R3 reads", n, 3);
    chk(c == 7, "R3 latency", c, 7);
    run(20'd1, 20'd2, 16'd100, 1'b0, st, ra, c, n);
    chk(st == 2'b01 && ra == 20'd1, "R4 first node", ra, 1);
    chk(c == 3 && n == 1, "R3 first latency", c, 3);
  endtask

  task automatic t_equal();
    logic [1:0] st; logic [19:0] ra; int c, n;
    run(20'd1, 20'd10, 16'd100, 1'b0, st, ra, c, n);
    chk(st == 2'b01 && ra == 20'd9, "R5 equal match", ra, 9);
  endtask

  task automatic t_end();
    logic [1:0] st; logic [19:0] ra; int c, n;
    run(20'd1, 20'd25, 16'd100, 1'b0, st, ra, c, n);
    chk(st == 2'b10, "R6 status", st, 2);
    chk(ra == 20'd0, "R6 addr", ra, 0);
    chk(n == 4, "R6 reads", n, 4);
  endtask

  task automatic t_timeout();
    logic [1:0] st; logic [19:0] ra; int c, n, extra;
    run(20'd1, 20'd25, 16'd2, 1'b0, st, ra, c, n);
    chk(st == 2'b11, "R7 status", st, 3);
    chk(ra == 20'd0 && n == 2, "R7 reads", n, 2);
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      if (rd_en) extra++;
      @(negedge clk);
    end
    chk(extra == 0, "R7 no more reads", extra, 0);
  endtask

  task automatic t_zero_addr();
    logic [1:0] st; logic [19:0] ra; int c, n;
    run(20'd0, 20'd5, 16'd100, 1'b0, st, ra, c, n);
    chk(st == 2'b10 && c == 1, "R8 empty list", c, 1);
    chk(n == 0, "R8 no read", n, 0);
  endtask

  task automatic t_zero_limit();
    logic [1:0] st; logic [19:0] ra; int c, n;
    run(20'd1, 20'd5, 16'd0, 1'b0, st, ra, c, n);
    chk(st == 2'b11 && c == 1, "R9 zero budget", st, 3);
    chk(n == 0 && ra == 20'd0, "R9 no read", n, 0);
  endtask

  task automatic t_busy();
    logic [1:0] st; logic [19:0] ra; int c, n;
    run(20'd1, 20'd25, 16'd100, 1'b1, st, ra, c, n);
    chk(st == 2'b10, "R10 status kept", st, 2);
    chk(n == 4, "R10 reads kept", n, 4);
  endtask

  task automatic t_priority();
    logic [1:0] st; logic [19:0] ra; int c, n;
    run(20'd1, 20'd20, 16'd100, 1'b0, st, ra, c, n);
    chk(st == 2'b01 && ra == 20'd12, "R12 match over tail", ra, 12);
    run(20'd5, 20'd10, 16'd2, 1'b0, st, ra, c, n);
    chk(st == 2'b01 && ra == 20'd9, "R12 match over budget", st, 1);
    run(20'd1, 20'd25, 16'd4, 1'b0, st, ra, c, n);
    chk(st == 2'b10, "R12 tail over budget", st, 2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put(1, 20'd5, 20'd3);
    put(5, 20'd9, 20'd7);
    put(9, 20'd12, 20'd10);
    put(12, 20'd0, 20'd20);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_found();
    t_equal();
    t_end();
    t_timeout();
    t_zero_addr();
    t_zero_limit();
    t_busy();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500us;
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule